// File: doc/BRIEF.md
# Dual-Operand Effective Address Generator

This block produces the memory addresses for one data-move operation with two operands, a source and a destination. Each operand names a pointer register from a bank of sixteen 16-bit working registers and picks one of six addressing modes. The block returns both addresses and flags any operand that does not touch memory. It also returns the updated pointer value for each operand whose mode changes its pointer. Decode, the register bank storage and the memory itself stay outside. The contents of the register bank arrive as one flat input vector.

The two operands choose their modes independently. They share one 4-bit index selector, which names the register added to the pointer in indexed mode. Each operand has its own signed step and its own literal. All arithmetic wraps modulo 2^16. An operation is presented with `in_valid`, and every result appears on the registered outputs one clock later. When both operands would write back the same pointer, the destination's write-back wins.

Top module: `dual_ea_gen`

## Requirements
- R1: During synchronous active-low reset, and on the first cycle after it, `out_valid`, `src_wb_en`, `dst_wb_en`, `src_nomem` and `dst_nomem` are 0.
- R2: Mode code 0 (direct): the operand's EA output is 0, its nomem flag is 1, and it makes no write-back.
- R3: Mode code 1 (indirect): EA = Wn, nomem = 0, no write-back.
- R4: Mode code 2 (post-modify): EA = Wn. Write-back of Wn + step, where step is the operand's 4-bit two's-complement step, sign-extended, modulo 2^16.
- R5: Mode code 3 (pre-modify): EA = Wn + step (sign-extended, modulo 2^16). The same value is written back to Wn.
- R6: Mode code 4 (indexed): EA = Wn + W[off_reg], modulo 2^16. One shared `off_reg` serves both operands. There is no write-back.
- R7: Mode code 5 (literal offset): EA = Wn + literal, modulo 2^16, with no write-back. When the operand's short flag is 1, only literal bits [7:0] are used, sign-extended. Otherwise all 16 bits are used.
- R8: Source and destination results are computed from their own mode codes in the same operation, whatever the other operand's mode is.
- R9: When both operands request a write-back to the same register index, only `dst_wb_en` is raised and `src_wb_en` is 0.
- R10: Outputs update one clock after a cycle with `in_valid` = 1. After a cycle with `in_valid` = 0, `out_valid`, `src_wb_en` and `dst_wb_en` are 0.
- R11: Mode codes 6 and 7 behave exactly as direct mode (EA 0, nomem 1, no write-back).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| regs_flat | input | 256 | Working register contents, register i at bits [16*i+15:16*i] |
| src_mode | input | 3 | Source addressing mode code |
| src_reg | input | 4 | Source pointer register index |
| src_step | input | 4 | Source signed modify step |
| src_lit | input | 16 | Source literal offset |
| src_lit_short | input | 1 | Source literal uses 8 sign-extended bits |
| dst_mode | input | 3 | Destination addressing mode code |
| dst_reg | input | 4 | Destination pointer register index |
| dst_step | input | 4 | Destination signed modify step |
| dst_lit | input | 16 | Destination literal offset |
| dst_lit_short | input | 1 | Destination literal uses 8 sign-extended bits |
| off_reg | input | 4 | Shared index register selector |
| out_valid | output | 1 | Registered results valid |
| src_ea | output | 16 | Source effective address |
| src_nomem | output | 1 | Source makes no memory access |
| src_wb_en | output | 1 | Source pointer write-back enable |
| src_wb_idx | output | 4 | Source write-back register index |
| src_wb_val | output | 16 | Source write-back value |
| dst_ea | output | 16 | Destination effective address |
| dst_nomem | output | 1 | Destination makes no memory access |
| dst_wb_en | output | 1 | Destination pointer write-back enable |
| dst_wb_idx | output | 4 | Destination write-back register index |
| dst_wb_val | output | 16 | Destination write-back value |

## Verification
The bench sweeps every pair of source and destination mode codes, every source pointer, and several register and literal patterns. Some of these patterns place a pointer at 0xFFFE, so that steps and offsets wrap past 2^16. A design that drops the carry or forgets sign extension would show wrong addresses there. A design that mixes up pre- and post-modify would give a post-modify EA that already includes the step. One pattern makes both operands name the same pointer. A merge that let the source win, or raised both enables, would report a second write to that register. The reserved codes and the idle cycles are checked too, so any stray write-back or memory flag on them would show.

// File: rtl/dual_ea_pkg.sv
// Package: shared addressing-mode codes for the dual EA generator.
// Assumes a 3-bit mode field; codes 6 and 7 are reserved and act as direct.
package dual_ea_pkg;

    typedef enum logic [2:0] {
        AM_DIRECT  = 3'd0,
        AM_IND     = 3'd1,
        AM_POSTMOD = 3'd2,
        AM_PREMOD  = 3'd3,
        AM_INDEXED = 3'd4,
        AM_LITOFF  = 3'd5,
        AM_RSV6    = 3'd6,
        AM_RSV7    = 3'd7
    } amode_t;

    // True for the modes that update their pointer register.
    function automatic logic mode_writes_back(input amode_t m);
        return (m == AM_POSTMOD) || (m == AM_PREMOD);
    endfunction

endpackage

// File: rtl/ea_reg_pick.sv
// Module: selects one working register value from the flat register bank.
// Assumes register i sits at bits [i*DW +: DW] of the flat vector.
module ea_reg_pick #(
    parameter int NREG  = 16,
    parameter int DW    = 16,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG*DW-1:0] bank_i,
    input  logic [IDX_W-1:0]   sel_i,
    output logic [DW-1:0]      val_o
);

    // Read mux over all bank entries.
    always_comb begin
        val_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel_i == IDX_W'(i)) val_o = bank_i[i*DW +: DW];
        end
    end

endmodule

// File: rtl/ea_operand_calc.sv
// Module: forms the EA, no-memory flag and pointer write-back of one operand.
// Assumes pointer and index values are already read; arithmetic wraps at 2^DW.
module ea_operand_calc
    import dual_ea_pkg::*;
#(
    parameter int DW      = 16,
    parameter int STEP_W  = 4,
    parameter int SHORT_W = 8
) (
    input  logic [2:0]      mode_i,
    input  logic [DW-1:0]   ptr_i,
    input  logic [DW-1:0]   index_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [DW-1:0]   lit_i,
    input  logic            lit_short_i,
    output logic [DW-1:0]   ea_o,
    output logic            nomem_o,
    output logic            wb_req_o,
    output logic [DW-1:0]   wb_val_o
);

    logic [DW-1:0] step_ext;
    logic [DW-1:0] lit_ext;
    logic [DW-1:0] stepped;
    amode_t        mode;

    // Sign-extend the step and select the literal width.
    always_comb begin
        step_ext = {{(DW-STEP_W){step_i[STEP_W-1]}}, step_i};
        lit_ext  = lit_short_i ? {{(DW-SHORT_W){lit_i[SHORT_W-1]}}, lit_i[SHORT_W-1:0]}
                               : lit_i;
        stepped  = ptr_i + step_ext;
        mode     = amode_t'(mode_i);
    end

    // Mode decode for EA, memory flag and write-back request.
    always_comb begin
        ea_o     = '0;
        nomem_o  = 1'b0;
        wb_val_o = stepped;
        wb_req_o = mode_writes_back(mode);
        case (mode)
            AM_IND:     ea_o = ptr_i;
            AM_POSTMOD: ea_o = ptr_i;
            AM_PREMOD:  ea_o = stepped;
            AM_INDEXED: ea_o = ptr_i + index_i;
            AM_LITOFF:  ea_o = ptr_i + lit_ext;
            default:    nomem_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/ea_wb_arbiter.sv
// Module: resolves two pointer write-back requests for one operation.
// Assumes the destination request outranks the source on an index clash.
module ea_wb_arbiter #(
    parameter int IDX_W = 4
) (
    input  logic             src_req_i,
    input  logic [IDX_W-1:0] src_idx_i,
    input  logic             dst_req_i,
    input  logic [IDX_W-1:0] dst_idx_i,
    output logic             src_en_o,
    output logic             dst_en_o
);

    // Suppress the source write-back when the destination targets the same register.
    always_comb begin
        dst_en_o = dst_req_i;
        src_en_o = src_req_i && !(dst_req_i && (src_idx_i == dst_idx_i));
    end

endmodule

// File: rtl/dual_ea_gen.sv
// Module: top of the dual-operand effective address generator.
// Reads pointers from the flat bank, computes both operands in parallel,
// arbitrates write-backs and registers every result when in_valid is high.
// Assumes synchronous active-low reset and a single shared index selector.
module dual_ea_gen
    import dual_ea_pkg::*;
#(
    parameter int NREG    = 16,
    parameter int DW      = 16,
    parameter int STEP_W  = 4,
    parameter int SHORT_W = 8,
    parameter int IDX_W   = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [NREG*DW-1:0] regs_flat,
    input  logic [2:0]         src_mode,
    input  logic [IDX_W-1:0]   src_reg,
    input  logic [STEP_W-1:0]  src_step,
    input  logic [DW-1:0]      src_lit,
    input  logic               src_lit_short,
    input  logic [2:0]         dst_mode,
    input  logic [IDX_W-1:0]   dst_reg,
    input  logic [STEP_W-1:0]  dst_step,
    input  logic [DW-1:0]      dst_lit,
    input  logic               dst_lit_short,
    input  logic [IDX_W-1:0]   off_reg,
    output logic               out_valid,
    output logic [DW-1:0]      src_ea,
    output logic               src_nomem,
    output logic               src_wb_en,
    output logic [IDX_W-1:0]   src_wb_idx,
    output logic [DW-1:0]      src_wb_val,
    output logic [DW-1:0]      dst_ea,
    output logic               dst_nomem,
    output logic               dst_wb_en,
    output logic [IDX_W-1:0]   dst_wb_idx,
    output logic [DW-1:0]      dst_wb_val
);

    localparam int NOPS = 2;

    logic [2:0]        op_mode  [NOPS];
    logic [IDX_W-1:0]  op_reg   [NOPS];
    logic [STEP_W-1:0] op_step  [NOPS];
    logic [DW-1:0]     op_lit   [NOPS];
    logic              op_short [NOPS];
    logic [DW-1:0]     op_ptr   [NOPS];
    logic [DW-1:0]     op_ea    [NOPS];
    logic              op_nomem [NOPS];
    logic              op_wbreq [NOPS];
    logic [DW-1:0]     op_wbval [NOPS];
    logic [DW-1:0]     index_val;
    logic              src_en_c;
    logic              dst_en_c;

    // Gather per-operand inputs into arrays (0 = source, 1 = destination).
    always_comb begin
        op_mode[0]  = src_mode;      op_mode[1]  = dst_mode;
        op_reg[0]   = src_reg;       op_reg[1]   = dst_reg;
        op_step[0]  = src_step;      op_step[1]  = dst_step;
        op_lit[0]   = src_lit;       op_lit[1]   = dst_lit;
        op_short[0] = src_lit_short; op_short[1] = dst_lit_short;
    end

    ea_reg_pick #(.NREG(NREG), .DW(DW), .IDX_W(IDX_W)) u_index_pick (
        .bank_i (regs_flat),
        .sel_i  (off_reg),
        .val_o  (index_val)
    );

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        ea_reg_pick #(.NREG(NREG), .DW(DW), .IDX_W(IDX_W)) u_ptr_pick (
            .bank_i (regs_flat),
            .sel_i  (op_reg[g]),
            .val_o  (op_ptr[g])
        );

        ea_operand_calc #(.DW(DW), .STEP_W(STEP_W), .SHORT_W(SHORT_W)) u_calc (
            .mode_i      (op_mode[g]),
            .ptr_i       (op_ptr[g]),
            .index_i     (index_val),
            .step_i      (op_step[g]),
            .lit_i       (op_lit[g]),
            .lit_short_i (op_short[g]),
            .ea_o        (op_ea[g]),
            .nomem_o     (op_nomem[g]),
            .wb_req_o    (op_wbreq[g]),
            .wb_val_o    (op_wbval[g])
        );
    end

    ea_wb_arbiter #(.IDX_W(IDX_W)) u_arb (
        .src_req_i (op_wbreq[0]),
        .src_idx_i (src_reg),
        .dst_req_i (op_wbreq[1]),
        .dst_idx_i (dst_reg),
        .src_en_o  (src_en_c),
        .dst_en_o  (dst_en_c)
    );

    // Result register: capture on in_valid, drop strobes otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            src_ea     <= '0;
            src_nomem  <= 1'b0;
            src_wb_en  <= 1'b0;
            src_wb_idx <= '0;
            src_wb_val <= '0;
            dst_ea     <= '0;
            dst_nomem  <= 1'b0;
            dst_wb_en  <= 1'b0;
            dst_wb_idx <= '0;
            dst_wb_val <= '0;
        end else begin
            out_valid <= in_valid;
            src_wb_en <= in_valid && src_en_c;
            dst_wb_en <= in_valid && dst_en_c;
            if (in_valid) begin
                src_ea     <= op_ea[0];
                src_nomem  <= op_nomem[0];
                src_wb_idx <= src_reg;
                src_wb_val <= op_wbval[0];
                dst_ea     <= op_ea[1];
                dst_nomem  <= op_nomem[1];
                dst_wb_idx <= dst_reg;
                dst_wb_val <= op_wbval[1];
            end
        end
    end

    assert_rst_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !src_wb_en && !dst_wb_en && !src_nomem && !dst_nomem));

    assert_direct_nomem_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_mode == 3'd0) |=> (src_nomem && !src_wb_en));

    assert_post_ea_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_mode == 3'd2) |=> (dst_ea == $past(op_ptr[1])));

    assert_index_nowb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_mode == 3'd4 && dst_mode == 3'd4) |=> (!src_wb_en && !dst_wb_en));

    assert_wb_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wb_en && dst_wb_en) |-> (src_wb_idx != dst_wb_idx));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !src_wb_en && !dst_wb_en));

    assert_rsv_direct_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_mode[2:1] == 2'b11) |=> (dst_nomem && dst_ea == '0 && !dst_wb_en));

endmodule

// File: tb/dual_ea_gen_tb.sv
`timescale 1ns/1ps
module dual_ea_gen_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [255:0] regs_flat;
    logic [2:0]   src_mode, dst_mode;
    logic [3:0]   src_reg, dst_reg, off_reg;
    logic [3:0]   src_step, dst_step;
    logic [15:0]  src_lit, dst_lit;
    logic         src_lit_short, dst_lit_short;
    logic         out_valid, src_nomem, dst_nomem, src_wb_en, dst_wb_en;
    logic [15:0]  src_ea, dst_ea, src_wb_val, dst_wb_val;
    logic [3:0]   src_wb_idx, dst_wb_idx;

    logic [15:0]  rv [16];
    int           total = 0;
    int           bad = 0;
    bit           done = 1'b0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 16; i++) regs_flat[i*16 +: 16] = rv[i];
    end

    dual_ea_gen dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .regs_flat(regs_flat),
        .src_mode(src_mode), .src_reg(src_reg), .src_step(src_step),
        .src_lit(src_lit), .src_lit_short(src_lit_short),
        .dst_mode(dst_mode), .dst_reg(dst_reg), .dst_step(dst_step),
        .dst_lit(dst_lit), .dst_lit_short(dst_lit_short), .off_reg(off_reg),
        .out_valid(out_valid), .src_ea(src_ea), .src_nomem(src_nomem),
        .src_wb_en(src_wb_en), .src_wb_idx(src_wb_idx), .src_wb_val(src_wb_val),
        .dst_ea(dst_ea), .dst_nomem(dst_nomem), .dst_wb_en(dst_wb_en),
        .dst_wb_idx(dst_wb_idx), .dst_wb_val(dst_wb_val)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R11";
        endcase
    endfunction

    // Expected operand results, written from the requirement text.
    task automatic model(input logic [2:0] m, input logic [15:0] b, input logic [15:0] ix,
                         input logic [3:0] st, input logic [15:0] lt, input logic sh,
                         output logic [15:0] ea, output logic nm, output logic we,
                         output logic [15:0] wv);
        int s = (st >= 8) ? int'(st) - 16 : int'(st);
        int l = sh ? ((lt[7:0] >= 128) ? int'(lt[7:0]) - 256 : int'(lt[7:0])) : int'(lt);
        ea = 16'h0; nm = 1'b0; we = 1'b0; wv = 16'h0;
        case (m)
            3'd1: ea = b;
            3'd2: begin ea = b; we = 1'b1; wv = 16'(int'(b) + s); end
            3'd3: begin ea = 16'(int'(b) + s); we = 1'b1; wv = ea; end
            3'd4: ea = 16'(int'(b) + int'(ix));
            3'd5: ea = 16'(int'(b) + l);
            default: nm = 1'b1;
        endcase
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] sea, dea, swv, dwv;
        logic snm, dnm, swe, dwe, sexp;
        for (int i = 0; i < 16; i++) rv[i] = 16'(i * 16'h1111);
        rst_n = 1'b0; in_valid = 1'b1;
        src_mode = 3'd2; dst_mode = 3'd3; src_reg = 4'd1; dst_reg = 4'd2; off_reg = 4'd0;
        src_step = 4'd1; dst_step = 4'd1; src_lit = '0; dst_lit = '0;
        src_lit_short = 1'b0; dst_lit_short = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "out_valid in reset", 32'(out_valid), 0);
        chk("R1", "wb enables in reset", {30'd0, src_wb_en, dst_wb_en}, 0);
        chk("R1", "nomem in reset", {30'd0, src_nomem, dst_nomem}, 0);
        rst_n = 1'b1;

        for (int sm = 0; sm < 8; sm++) begin
            for (int dm = 0; dm < 8; dm++) begin
                for (int sr = 0; sr < 16; sr++) begin
                    for (int v = 0; v < 4; v++) begin
                        for (int i = 0; i < 16; i++)
                            rv[i] = 16'(i * 16'h1111 + v * 16'h03C5 + sm * 7 + dm * 13);
                        if (v == 3) rv[sr] = 16'hFFFE;
                        src_mode = 3'(sm); dst_mode = 3'(dm);
                        src_reg = 4'(sr);
                        dst_reg = (v == 1) ? 4'(sr) : 4'(sr + v * 5 + 1);
                        off_reg = 4'(sr + v + 3);
                        src_step = 4'(v * 3 + sr);
                        dst_step = 4'(sr ^ v ^ 10);
                        src_lit = 16'(sr * 16'h0811 + v * 16'h007F);
                        dst_lit = ~src_lit;
                        src_lit_short = v[0];
                        dst_lit_short = ~v[0];
                        in_valid = 1'b1;
                        model(src_mode, rv[src_reg], rv[off_reg], src_step, src_lit,
                              src_lit_short, sea, snm, swe, swv);
                        model(dst_mode, rv[dst_reg], rv[off_reg], dst_step, dst_lit,
                              dst_lit_short, dea, dnm, dwe, dwv);
                        sexp = swe && !(dwe && src_reg == dst_reg);
                        @(posedge clk);
                        @(negedge clk);
                        chk("R10", "out_valid after op", 32'(out_valid), 1);
                        chk(tag_of(src_mode), "src_ea", 32'(src_ea), 32'(sea));
                        chk(tag_of(src_mode), "src_nomem", 32'(src_nomem), 32'(snm));
                        chk(tag_of(dst_mode), "dst_ea", 32'(dst_ea), 32'(dea));
                        chk(tag_of(dst_mode), "dst_nomem", 32'(dst_nomem), 32'(dnm));
                        chk(tag_of(dst_mode), "dst_wb_en", 32'(dst_wb_en), 32'(dwe));
                        if (swe && dwe && src_reg == dst_reg)
                            chk("R9", "src_wb_en on clash", 32'(src_wb_en), 32'(sexp));
                        else
                            chk(tag_of(src_mode), "src_wb_en", 32'(src_wb_en), 32'(sexp));
                        if (sexp) begin
                            chk(tag_of(src_mode), "src_wb_val", 32'(src_wb_val), 32'(swv));
                            chk(tag_of(src_mode), "src_wb_idx", 32'(src_wb_idx), 32'(src_reg));
                        end
                        if (dwe) begin
                            chk(tag_of(dst_mode), "dst_wb_val", 32'(dst_wb_val), 32'(dwv));
                            chk(tag_of(dst_mode), "dst_wb_idx", 32'(dst_wb_idx), 32'(dst_reg));
                        end
                        if (sm != dm)
                            chk("R8", "independent modes", {src_ea, dst_ea}, {sea, dea});
                    end
                end
            end
        end

        in_valid = 1'b0;
        src_mode = 3'd2; dst_mode = 3'd3;
        @(posedge clk);
        @(negedge clk);
        chk("R10", "out_valid idle", 32'(out_valid), 0);
        chk("R10", "wb enables idle", {30'd0, src_wb_en, dst_wb_en}, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule